// File: doc/BRIEF.md
# SAR Converter Bus Interface Controller

This block is the digital half of a 12-bit successive-approximation converter with a parallel, microprocessor-style read port. A host selects the part with an active-low chip select and pulls an active-low read strobe. When the high-byte select is low, that same read starts a new conversion. When it is high, the read only returns data. The strobes are asynchronous to the converter clock. They pass through a two-flop synchroniser, and the start is taken from the synchronised falling edge of the read strobe.

A conversion spends one clock settling and then twelve clocks deciding bits, most significant first. Each step tries a 1 in the current bit and keeps it only when the external comparator bit is 1. An active-low busy flag covers the whole conversion. The result register keeps the previous value until the last decision and is then replaced in one clock.

The twelve data lines are tri-state and are driven only while chip select and read are both low. With the high-byte select low they carry the full word. With it high, the top four result bits appear on both the top and bottom nibbles and the middle nibble is zero. This lets an 8-bit bus read the upper bits on its low lines.

Top module: `sar_bus_ctrl`

## Requirements
- R1: A falling edge of rd_ni, with cs_ni and hben_i low, starts a conversion. busy_no is first seen low three clock edges after the inputs change: two synchroniser flops plus one state register.
- R2: A read with hben_i high starts no conversion, and busy_no stays high.
- R3: With cs_ni high, rd_ni and hben_i are ignored: no conversion starts and the data lines stay undriven.
- R4: data_oe_o is high, and data_o is driven, only while cs_ni and rd_ni are both low. This follows the pins without a clock. Otherwise data_o is high-impedance.
- R5: busy_no stays low for exactly 13 clock cycles per conversion: 1 settling cycle plus 12 bit decisions.
- R6: Bits are resolved from bit 11 down to bit 0, one per clock. A comparator value of 1 keeps the trial bit and 0 clears it, so the result equals the comparator values in that order.
- R7: With hben_i low, data_o[11:0] equals result bits 11 down to 0.
- R8: With hben_i high, data_o[11:8] equals result[11:8], data_o[7:4] is 0 and data_o[3:0] equals result[11:8].
- R9: A start request made while busy_no is low is ignored. busy_no rises after 13 cycles and stays high.
- R10: The result seen on the bus keeps the previous value during a conversion. It takes the new value on the edge where busy_no rises.
- R11: rst_ni low asynchronously returns the sequencer to idle, sets busy_no high and clears the result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low; also the conversion start |
| hben_i | input | 1 | High-byte select; high folds the output and blocks starts |
| cmp_i | input | 1 | Comparator decision for the current trial bit |
| busy_no | output | 1 | Low while a conversion runs |
| data_oe_o | output | 1 | Pad enable for the data lines |
| data_o | output | 12 | Tri-state result bus |

## Verification
The bench counts the clock edges from the read strobe to the fall of busy_no. A synchroniser that is one flop short, or an edge detector on the wrong polarity, shows up there as a latency other than three. It feeds alternating, all-zero, all-one and single-bit comparator patterns. A sequencer that runs from the wrong end, or that drops the trial bit, returns a wrong word. A second read strobe is pulsed in the middle of a conversion. A design that restarts on it stretches busy or loses the result. Reads are made with chip select high and with the high-byte select set, and a reset is applied mid-conversion. These catch a bus that drives when it should float, a fold that misplaces a nibble, and a reset that leaves the old result behind.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned SAR_RES_W = 12;
  localparam int unsigned SAR_BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SETTLE = 2'd1,
    ST_DECIDE = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sar_start_det.sv
module sar_start_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_s_ni,
  input  logic cs_s_ni,
  input  logic hben_s_i,
  output logic start_o
);
  logic rd_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_prev_q <= 1'b1;
    else         rd_prev_q <= rd_s_ni;
  end

  // falling read edge, only when selected and not in byte mode
  assign start_o = rd_prev_q & ~rd_s_ni & ~cs_s_ni & ~hben_s_i;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int unsigned WIDTH = SAR_RES_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             busy_no,
  output logic [WIDTH-1:0] result_o
);
  localparam int unsigned IDX_W = $clog2(WIDTH);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(WIDTH - 1);
  localparam logic [WIDTH-1:0] MSB_TRIAL = {1'b1, {(WIDTH-1){1'b0}}};

  sar_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [WIDTH-1:0] trial_q;
  logic [WIDTH-1:0] trial_nxt;
  logic [WIDTH-1:0] result_q;
  logic             busy_q;

  always_comb begin
    trial_nxt = trial_q;
    trial_nxt[idx_q] = cmp_i;
    if (idx_q != '0) trial_nxt[idx_q - IDX_W'(1)] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      busy_q   <= 1'b1;
      idx_q    <= '0;
      trial_q  <= '0;
      result_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SETTLE;
            busy_q  <= 1'b0;
          end
        end
        ST_SETTLE: begin
          state_q <= ST_DECIDE;
          idx_q   <= IDX_TOP;
          trial_q <= MSB_TRIAL;
        end
        ST_DECIDE: begin
          trial_q <= trial_nxt;
          if (idx_q == '0) begin
            result_q <= trial_nxt;
            busy_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            idx_q <= idx_q - IDX_W'(1);
          end
        end
        default: begin
          state_q <= ST_IDLE;
          busy_q  <= 1'b1;
        end
      endcase
    end
  end

  assign busy_no  = busy_q;
  assign result_o = result_q;
endmodule

// File: rtl/sar_out_mux.sv
module sar_out_mux
  import sar_pkg::*;
#(
  parameter int unsigned WIDTH = SAR_RES_W
) (
  input  logic             cs_ni,
  input  logic             rd_ni,
  input  logic             hben_i,
  input  logic [WIDTH-1:0] result_i,
  output logic             oe_o,
  output logic [WIDTH-1:0] data_o
);
  localparam int unsigned LO_W = SAR_BYTE_W;
  localparam int unsigned HI_W = WIDTH - LO_W;

  logic [WIDTH-1:0] fold;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fold
    if (i >= LO_W) begin : g_hi
      assign fold[i] = result_i[i];
    end else if (i >= HI_W) begin : g_zero
      assign fold[i] = 1'b0;
    end else begin : g_rep
      assign fold[i] = result_i[i + LO_W];
    end
  end

  assign oe_o   = ~cs_ni & ~rd_ni;
  assign data_o = oe_o ? (hben_i ? fold : result_i) : 'z;
endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned RES_W = SAR_RES_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             rd_ni,
  input  logic             hben_i,
  input  logic             cmp_i,
  output logic             busy_no,
  output logic             data_oe_o,
  output logic [RES_W-1:0] data_o
);
  logic [2:0]       strb_s;
  logic             start;
  logic [RES_W-1:0] result_q;

  // {hben, cs, rd}: idle values 0, 1, 1
  sar_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b011)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({hben_i, cs_ni, rd_ni}),
    .q_o   (strb_s)
  );

  sar_start_det u_start (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_s_ni (strb_s[0]),
    .cs_s_ni (strb_s[1]),
    .hben_s_i(strb_s[2]),
    .start_o (start)
  );

  sar_seq #(.WIDTH(RES_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .cmp_i   (cmp_i),
    .busy_no (busy_no),
    .result_o(result_q)
  );

  sar_out_mux #(.WIDTH(RES_W)) u_mux (
    .cs_ni   (cs_ni),
    .rd_ni   (rd_ni),
    .hben_i  (hben_i),
    .result_i(result_q),
    .oe_o    (data_oe_o),
    .data_o  (data_o)
  );
endmodule

// File: rtl/sar_bus_ctrl_chk.sv
module sar_bus_ctrl_chk #(
  parameter int unsigned RES_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hben_i,
  input logic             busy_no,
  input logic             data_oe_o,
  input logic [RES_W-1:0] data_o,
  input logic [RES_W-1:0] res_q
);
  localparam int unsigned CONV_CYC = RES_W + 1;
  localparam int unsigned CNT_W = $clog2(CONV_CYC + 2);
  localparam int unsigned HI_W = RES_W - 8;

  logic [CNT_W-1:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            low_cnt <= '0;
    else if (busy_no)                       low_cnt <= '0;
    else if (low_cnt != CNT_W'(CONV_CYC+1)) low_cnt <= low_cnt + 1'b1;
  end

  p_busy_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_no |-> low_cnt < CNT_W'(CONV_CYC));

  p_busy_exact_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_no) |-> low_cnt == CNT_W'(CONV_CYC));

  p_res_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_no && $past(!busy_no)) |-> $stable(res_q));

  p_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && !hben_i) |-> data_o == res_q);

  p_fold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && hben_i) |->
      (data_o[7:HI_W] == '0 && data_o[HI_W-1:0] == data_o[RES_W-1:8]));
endmodule

bind sar_bus_ctrl sar_bus_ctrl_chk #(.RES_W(RES_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .hben_i   (hben_i),
  .busy_no  (busy_no),
  .data_oe_o(data_oe_o),
  .data_o   (data_o),
  .res_q    (result_q)
);

// File: tb/tb_sar_bus_ctrl.sv
module tb_sar_bus_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1;
  logic rd_ni = 1'b1;
  logic hben_i = 1'b0;
  logic cmp_i = 1'b0;
  logic busy_no;
  logic data_oe;
  wire [11:0] data_w;
  int n_chk = 0;
  int n_err = 0;

  localparam int NVEC = 6;
  localparam logic [11:0] VEC [NVEC] = '{12'h000, 12'hFFF, 12'hA5C, 12'h801, 12'h7FE, 12'h35A};

  always #4 clk = ~clk;

  sar_bus_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .rd_ni(rd_ni),
    .hben_i(hben_i), .cmp_i(cmp_i), .busy_no(busy_no),
    .data_oe_o(data_oe), .data_o(data_w)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] fold(input logic [11:0] r);
    return {r[11:8], 4'h0, r[11:8]};
  endfunction

  // byte-mode read: checks fold (R8) and that no conversion starts (R2)
  task automatic read_hi(input logic [11:0] r);
    @(negedge clk);
    cs_ni = 1'b0; hben_i = 1'b1; rd_ni = 1'b0;
    #1;
    check(data_oe == 1'b1, "R4", data_oe, 1);
    check(data_w == fold(r), "R8", data_w, fold(r));
    repeat (5) @(negedge clk);
    check(busy_no == 1'b1, "R2", busy_no, 1);
    rd_ni = 1'b1;
    repeat (3) @(negedge clk);
    cs_ni = 1'b1; hben_i = 1'b0;
  endtask

  task automatic conv(input logic [11:0] t, input logic [11:0] prev, input bit poke);
    int lat;
    @(negedge clk);
    cs_ni = 1'b0; hben_i = 1'b0; rd_ni = 1'b0;
    #1;
    check(data_w == prev, "R7", data_w, prev);
    lat = 0;
    while (busy_no && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 3, "R1", lat, 3);
    rd_ni = 1'b1; cs_ni = 1'b1;
    @(negedge clk);
    check(busy_no == 1'b0, "R5", busy_no, 0);
    for (int k = 11; k >= 0; k--) begin
      cmp_i = t[k];
      if (poke && k == 9) begin
        cs_ni = 1'b0; rd_ni = 1'b0;
        #1;
        check(data_w == prev, "R10", data_w, prev);
      end
      if (poke && k == 6) begin
        rd_ni = 1'b1; cs_ni = 1'b1;
      end
      @(negedge clk);
      if (k > 0) check(busy_no == 1'b0, "R5", busy_no, 0);
    end
    check(busy_no == 1'b1, "R5", busy_no, 1);
    if (poke) begin
      for (int j = 0; j < 6; j++) begin
        @(negedge clk);
        check(busy_no == 1'b1, "R9", busy_no, 1);
      end
    end
  endtask

  initial begin
    logic [11:0] prev;
    repeat (3) @(negedge clk);
    check(busy_no == 1'b1, "R11", busy_no, 1);
    check(data_oe == 1'b0, "R4", data_oe, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    read_hi(12'h000);

    // R3: strobes with chip select high
    @(negedge clk);
    cs_ni = 1'b1; hben_i = 1'b0; rd_ni = 1'b0;
    #1;
    check(data_oe == 1'b0, "R3", data_oe, 0);
    repeat (5) @(negedge clk);
    check(busy_no == 1'b1, "R3", busy_no, 1);
    rd_ni = 1'b1;
    repeat (3) @(negedge clk);
    // R4: selected without read strobe
    cs_ni = 1'b0;
    #1;
    check(data_oe == 1'b0, "R4", data_oe, 0);
    cs_ni = 1'b1;

    // R6: table of comparator patterns
    prev = 12'h000;
    for (int i = 0; i < NVEC; i++) begin
      conv(VEC[i], prev, 1'b0);
      read_hi(VEC[i]);
      prev = VEC[i];
    end

    // R9: second start during conversion
    conv(12'hC3A, prev, 1'b1);
    read_hi(12'hC3A);

    // R11: reset mid-conversion
    @(negedge clk);
    cs_ni = 1'b0; hben_i = 1'b0; rd_ni = 1'b0;
    #1;
    check(data_w == 12'hC3A, "R7", data_w, 12'hC3A);
    repeat (5) @(negedge clk);
    check(busy_no == 1'b0, "R1", busy_no, 0);
    rst_ni = 1'b0;
    #1;
    check(busy_no == 1'b1, "R11", busy_no, 1);
    rd_ni = 1'b1; cs_ni = 1'b1;
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    read_hi(12'h000);
    @(negedge clk);
    cs_ni = 1'b0; hben_i = 1'b0; rd_ni = 1'b0;
    #1;
    check(data_w == 12'h000, "R11", data_w, 0);
    rd_ni = 1'b1; cs_ni = 1'b1;
    repeat (4) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule